// File: doc/BRIEF.md
# Single-Entry Posted Write Buffer

This block sits between an instruction sequencer and the bus controller and holds one operand write (address, data and size) that has been handed over but not yet finished on the bus. When the slot is empty, a write is taken in the cycle it is requested. The sequencer then moves on at once, so the last write of one instruction runs on the bus while the next instruction starts.

The slot is never overwritten. A second write that arrives while the slot is occupied is held off with a stall until the bus reports that the pending write is done. A read is also stalled if it touches the same aligned long word as the pending write, so it cannot return data from before that write. A read to any other word goes ahead while the write drains.

Top module: `write_pend_buf`

## Requirements
- R1: After reset the slot is empty: `bus_req_o` and `stall_o` are both low.
- R2: A write request while the slot is empty is accepted with `stall_o` low. From the next cycle, `bus_req_o` is high and `bus_addr_o`, `bus_data_o` and `bus_size_o` carry the accepted address, data and size.
- R3: `bus_req_o` stays high and the buffered fields hold steady until `bus_gnt_i` is seen high. In the cycle after the grant, `bus_req_o` is low while the slot waits for completion.
- R4: A write request while the slot is occupied raises `stall_o` in that cycle, and the buffered address, data and size are left unchanged.
- R5: `bus_done_i` frees the slot at that clock edge. A write that is stalled in the done cycle still sees `stall_o` high in that cycle and is accepted, with `stall_o` low, in the following cycle.
- R6: A read request while the slot is occupied stalls when `rd_addr_i` equals the buffered address in all bits above bit 1. Reads to a different long word, and any read while the slot is empty, are not stalled.
- R7: `stall_o` is low in every cycle in which neither a read nor a write is requested.
- R8: The size code is passed to the bus unchanged: 0 byte, 1 word, 2 long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Sequencer requests an operand write |
| wr_addr_i | input | 32 | Write address |
| wr_data_i | input | 32 | Write data |
| wr_size_i | input | 2 | Write size code (0 byte, 1 word, 2 long) |
| rd_req_i | input | 1 | Sequencer requests an operand read |
| rd_addr_i | input | 32 | Read address |
| stall_o | output | 1 | Current request must be held and repeated |
| bus_req_o | output | 1 | Buffered write requests the bus |
| bus_addr_o | output | 32 | Buffered address |
| bus_data_o | output | 32 | Buffered data |
| bus_size_o | output | 2 | Buffered size code |
| bus_gnt_i | input | 1 | Bus controller grants the request |
| bus_done_i | input | 1 | Bus controller finished the buffered write |

## Verification
The hardest case to reach is a second write that is stalled in exactly the cycle in which the bus reports completion. That write must still see a stall in that cycle and must be accepted in the next one. The directed stimulus gets there in steps: it fills the slot, holds off the grant for several cycles, grants, parks a second write on the stall, and only then raises `bus_done_i` for a single cycle while the write request is still held. While the first write is still pending, reads are sent both inside and outside its long word to check where the address comparison draws the line.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } wsize_e;
endpackage

// File: rtl/wpb_hazard.sv
module wpb_hazard #(
  parameter int ADDR_W    = 32,
  parameter int MATCH_LSB = 2
) (
  input  logic              wr_req_i,
  input  logic              rd_req_i,
  input  logic              full_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] buf_addr_i,
  output logic              accept_o,
  output logic              stall_o
);
  logic [ADDR_W-1:0] diff;
  logic              same_word;

  assign diff      = (rd_addr_i ^ buf_addr_i) >> MATCH_LSB;
  assign same_word = (diff == '0);
  assign accept_o  = wr_req_i && !full_i;
  // occupied slot blocks writes; reads only when they hit the pending word
  assign stall_o   = full_i && ((wr_req_i) || (rd_req_i && same_word));
endmodule

// File: rtl/wpb_entry.sv
module wpb_entry #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic                done_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  input  wpb_pkg::wsize_e     size_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   data_o,
  output wpb_pkg::wsize_e     size_o,
  output logic                full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
      size_o <= wpb_pkg::SZ_BYTE;
    end else begin
      if (accept_i) begin
        full_o <= 1'b1;
        addr_o <= addr_i;
        data_o <= data_i;
        size_o <= size_i;
      end else if (done_i) begin
        full_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wpb_bus_seq.sv
module wpb_bus_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_i,
  input  logic gnt_i,
  input  logic done_i,
  output logic req_o
);
  logic busy_q;

  assign req_o = full_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               busy_q <= 1'b0;
    else if (done_i)           busy_q <= 1'b0;
    else if (req_o && gnt_i)   busy_q <= 1'b1;
  end
endmodule

// File: rtl/write_pend_buf.sv
module write_pend_buf #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MATCH_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        wr_size_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              stall_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic [1:0]        bus_size_o,
  input  logic              bus_gnt_i,
  input  logic              bus_done_i
);
  logic            full;
  logic            accept;
  wpb_pkg::wsize_e size_q;

  wpb_hazard #(.ADDR_W(ADDR_W), .MATCH_LSB(MATCH_LSB)) u_hazard (
    .wr_req_i  (wr_req_i),
    .rd_req_i  (rd_req_i),
    .full_i    (full),
    .rd_addr_i (rd_addr_i),
    .buf_addr_i(bus_addr_o),
    .accept_o  (accept),
    .stall_o   (stall_o)
  );

  wpb_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_entry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .done_i  (bus_done_i),
    .addr_i  (wr_addr_i),
    .data_i  (wr_data_i),
    .size_i  (wpb_pkg::wsize_e'(wr_size_i)),
    .addr_o  (bus_addr_o),
    .data_o  (bus_data_o),
    .size_o  (size_q),
    .full_o  (full)
  );

  assign bus_size_o = size_q;

  wpb_bus_seq u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .full_i(full),
    .gnt_i (bus_gnt_i),
    .done_i(bus_done_i),
    .req_o (bus_req_o)
  );
endmodule

// File: rtl/wpb_chk.sv
module wpb_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MATCH_LSB = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_req_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [1:0]        wr_size_i,
  input logic              rd_req_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              stall_o,
  input logic              bus_req_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_data_o,
  input logic [1:0]        bus_size_o,
  input logic              bus_gnt_i,
  input logic              bus_done_i,
  input logic              full
);
  // R2
  accept_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && !stall_o) |=> (bus_req_o && bus_addr_o == $past(wr_addr_i)
      && bus_data_o == $past(wr_data_i) && bus_size_o == $past(wr_size_i)));

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i && !bus_done_i) |=> (bus_req_o && $stable(bus_addr_o)
      && $stable(bus_data_o)));

  // R4
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && stall_o) |=> ($stable(bus_addr_o) && $stable(bus_data_o)
      && $stable(bus_size_o)));

  // R5
  done_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_done_i |=> !bus_req_o);

  // R6
  read_hazard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && full && ((rd_addr_i >> MATCH_LSB) == (bus_addr_o >> MATCH_LSB)))
      |-> stall_o);

  // R7
  idle_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_req_i && !rd_req_i) |-> !stall_o);
endmodule

bind write_pend_buf wpb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MATCH_LSB(MATCH_LSB)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_req_i  (wr_req_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .wr_size_i (wr_size_i),
  .rd_req_i  (rd_req_i),
  .rd_addr_i (rd_addr_i),
  .stall_o   (stall_o),
  .bus_req_o (bus_req_o),
  .bus_addr_o(bus_addr_o),
  .bus_data_o(bus_data_o),
  .bus_size_o(bus_size_o),
  .bus_gnt_i (bus_gnt_i),
  .bus_done_i(bus_done_i),
  .full      (full)
);

// File: tb/write_pend_buf_bench.sv
module write_pend_buf_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_req_i = 1'b0;
  logic [31:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  wr_size_i = '0;
  logic        rd_req_i = 1'b0;
  logic [31:0] rd_addr_i = '0;
  logic        stall_o, bus_req_o, bus_gnt_i = 1'b0, bus_done_i = 1'b0;
  logic [31:0] bus_addr_o, bus_data_o;
  logic [1:0]  bus_size_o;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [31:0] A0 = 32'h0000_1004;
  localparam logic [31:0] D0 = 32'hCAFE_0001;
  localparam logic [31:0] A1 = 32'h0000_2002;
  localparam logic [31:0] D1 = 32'h0BAD_F00D;
  localparam logic [31:0] A2 = 32'h0000_3001;
  localparam logic [31:0] D2 = 32'h0000_00A5;

  always #5 clk_i = ~clk_i;

  write_pend_buf u_write_pend_buf (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // advance one clock; inputs change 2 ns after the edge
  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic t_reset();
    #2;
    check("R1 bus_req after reset", {31'b0, bus_req_o}, 32'd0);
    check("R1 stall after reset", {31'b0, stall_o}, 32'd0);
  endtask

  task automatic t_accept();
    wr_req_i = 1'b1; wr_addr_i = A0; wr_data_i = D0; wr_size_i = 2'd2;
    #2;
    check("R2 no stall when empty", {31'b0, stall_o}, 32'd0);
    step();
    wr_req_i = 1'b0;
    #2;
    check("R2 bus_req raised", {31'b0, bus_req_o}, 32'd1);
    check("R2 bus_addr", bus_addr_o, A0);
    check("R2 bus_data", bus_data_o, D0);
    check("R8 long size code", {30'b0, bus_size_o}, 32'd2);
  endtask

  task automatic t_hold_grant();
    for (int i = 0; i < 3; i++) begin
      step();
      check("R3 req held without grant", {31'b0, bus_req_o}, 32'd1);
      check("R3 addr stable", bus_addr_o, A0);
    end
    bus_gnt_i = 1'b1;
    step();
    bus_gnt_i = 1'b0;
    #2;
    check("R3 req dropped after grant", {31'b0, bus_req_o}, 32'd0);
  endtask

  task automatic t_reads();
    rd_req_i = 1'b1; rd_addr_i = A0 + 32'd2;
    #2;
    check("R6 same long word read stalls", {31'b0, stall_o}, 32'd1);
    rd_addr_i = A0 + 32'd8;
    #2;
    check("R6 other word read passes", {31'b0, stall_o}, 32'd0);
    rd_req_i = 1'b0;
    #2;
    check("R7 idle no stall", {31'b0, stall_o}, 32'd0);
  endtask

  task automatic t_full_then_done();
    step();
    wr_req_i = 1'b1; wr_addr_i = A1; wr_data_i = D1; wr_size_i = 2'd1;
    #2;
    check("R4 write stalls when full", {31'b0, stall_o}, 32'd1);
    step();
    check("R4 addr unchanged", bus_addr_o, A0);
    check("R4 data unchanged", bus_data_o, D0);
    bus_done_i = 1'b1;
    #2;
    check("R5 still stalled in done cycle", {31'b0, stall_o}, 32'd1);
    step();
    bus_done_i = 1'b0;
    #2;
    check("R5 accepted cycle after done", {31'b0, stall_o}, 32'd0);
    step();
    wr_req_i = 1'b0;
    #2;
    check("R5 second write requested", {31'b0, bus_req_o}, 32'd1);
    check("R5 second write addr", bus_addr_o, A1);
    check("R5 second write data", bus_data_o, D1);
    check("R8 word size code", {30'b0, bus_size_o}, 32'd1);
    bus_gnt_i = 1'b1;
    step();
    bus_gnt_i = 1'b0;
    bus_done_i = 1'b1;
    step();
    bus_done_i = 1'b0;
    #2;
    check("R5 buffer freed", {31'b0, bus_req_o}, 32'd0);
    rd_req_i = 1'b1; rd_addr_i = A1;
    #2;
    check("R6 read when empty passes", {31'b0, stall_o}, 32'd0);
    rd_req_i = 1'b0;
  endtask

  task automatic t_byte();
    step();
    wr_req_i = 1'b1; wr_addr_i = A2; wr_data_i = D2; wr_size_i = 2'd0;
    #2;
    check("R2 byte write accepted", {31'b0, stall_o}, 32'd0);
    step();
    wr_req_i = 1'b0;
    #2;
    check("R8 byte size code", {30'b0, bus_size_o}, 32'd0);
    check("R2 byte write addr", bus_addr_o, A2);
    rd_req_i = 1'b1; rd_addr_i = 32'h0000_3003;
    #2;
    check("R6 read in byte write's word stalls", {31'b0, stall_o}, 32'd1);
    rd_req_i = 1'b0;
  endtask

  initial begin
    #23;
    t_reset();
    rst_ni = 1'b1;
    step();
    t_accept();
    t_hold_grant();
    t_reads();
    t_full_then_done();
    t_byte();
    step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule